// File: doc/BRIEF.md
# Shared float-integer register access

This block gives a core one place to fetch and store floating-point operands, whichever register file holds them. A static configuration input picks the file. When it selects the dedicated float file, operands narrower than a float register are stored with every unused upper bit set to one. A narrow read checks that padding and returns the canonical quiet NaN of its width when the padding is broken. When it selects the integer file, floating-point values live in the general-purpose registers. Narrow reads take the low bits there, and writes are sign-extended to the full register width.

On a 32-bit integer datapath a 64-bit operand does not fit in one register. It then occupies an even/odd pair: the even register holds the low half and the odd register holds the high half. Pair index zero behaves like the hard-wired zero register: it reads as zero and ignores writes. An odd pair index, a reserved width code, or a width wider than the float registers raises a combinational illegal-access flag, and an illegal write stores nothing. The block has two combinational read ports and one write port that commits on the clock edge.

Top module: `shared_fp_regs`

## Requirements
- R1: A synchronous active-high reset clears every entry of both register files to zero.
- R2: Width codes are 2'b00 = 16 bits, 2'b01 = 32 bits, 2'b10 = 64 bits and 2'b11 = reserved. A reserved code, or a width above FLEN, raises `illegal`, an illegal write changes no register, and an illegal read returns zero.
- R3: In float mode (`cfg_int_mode` = 0), a write narrower than FLEN stores the value in the low bits and sets all bits above it to one.
- R4: In float mode, a narrow read returns the low bits, zero-extended, when all bits above them are ones. Otherwise it returns the canonical quiet NaN: 16'h7E00 for 16 bits and 32'h7FC00000 for 32 bits.
- R5: In integer mode (`cfg_int_mode` = 1), a single-register read returns the low n bits of the register, zero-extended to FLEN.
- R6: In integer mode, a single-register write stores the n-bit value sign-extended to XLEN.
- R7: Integer register 0 always reads as zero, and writes to it are discarded. Float register 0 is an ordinary register.
- R8: With XLEN = 32, a 64-bit integer-mode read at an even nonzero index i returns register i+1 in bits 63:32 and register i in bits 31:0. At index 0 it returns zero.
- R9: With XLEN = 32, a 64-bit integer-mode write at an even nonzero index i stores bits 31:0 in register i and bits 63:32 in register i+1. At index 0 nothing is stored.
- R10: With XLEN = 32, a 64-bit integer-mode access at an odd index raises `illegal`. The write stores nothing, and the read returns zero.
- R11: Writes go only to the file the mode selects, and reads come only from that file.
- R12: Reads are combinational and show the old contents until the clock edge that commits a write to the same register. From that edge on, both read ports show the new contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_int_mode | input | 1 | 1 = operands in integer file, 0 = float file |
| ra_idx | input | 5 | Read port A register index |
| ra_wid | input | 2 | Read port A width code |
| ra_data | output | FLEN | Read port A operand |
| rb_idx | input | 5 | Read port B register index |
| rb_wid | input | 2 | Read port B width code |
| rb_data | output | FLEN | Read port B operand |
| wr_en | input | 1 | Write request |
| wr_idx | input | 5 | Write register index |
| wr_wid | input | 2 | Write width code |
| wr_data | input | FLEN | Write operand, value in low bits |
| illegal | output | 1 | Illegal access on any active port |

## Verification
A write and a combinational read of the register it targets can fall in the same cycle. The sharper case is a 64-bit paired write at register 12 while the other read port reads register 13, the high half of that pair. The bench holds both requests across one clock edge. It samples the read port before the edge and expects the old contents. It samples again after the edge and expects the new high half, so neither port ever sees a half-committed pair.

// File: rtl/fxr_pkg.sv
package fxr_pkg;

  typedef enum logic [1:0] {
    FW_H    = 2'b00,
    FW_S    = 2'b01,
    FW_D    = 2'b10,
    FW_RSVD = 2'b11
  } fwid_e;

  function automatic int unsigned wid_bits(input logic [1:0] w);
    case (w)
      2'b00:   return 16;
      2'b01:   return 32;
      2'b10:   return 64;
      default: return 0;
    endcase
  endfunction

  function automatic logic [63:0] low_mask(input int unsigned bits);
    logic [63:0] m;
    for (int b = 0; b < 64; b++) m[b] = (b < bits);
    return m;
  endfunction

  function automatic logic [63:0] canon_nan(input int unsigned bits);
    case (bits)
      16:      return 64'h0000_0000_0000_7E00;
      32:      return 64'h0000_0000_7FC0_0000;
      default: return 64'h7FF8_0000_0000_0000;
    endcase
  endfunction

  // Access is legal when the width code is defined, fits the float width,
  // and a paired access (32-bit integer file, 64-bit operand) is even.
  function automatic logic access_ok(input logic int_mode, input logic [1:0] w,
                                     input logic lsb, input int unsigned xlen,
                                     input int unsigned flen);
    int unsigned bits;
    bits = wid_bits(w);
    if (bits == 0) return 1'b0;
    if (bits > flen) return 1'b0;
    if (int_mode && xlen == 32 && bits == 64 && lsb) return 1'b0;
    return 1'b1;
  endfunction

endpackage

// File: rtl/fxr_rd_port.sv
module fxr_rd_port
  import fxr_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int FLEN  = 64,
  parameter int IDX_W = 5
) (
  input  logic             int_mode,
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       wid,
  input  logic [FLEN-1:0]  f_word,
  input  logic [XLEN-1:0]  x_lo,
  input  logic [XLEN-1:0]  x_hi,
  output logic [FLEN-1:0]  data,
  output logic             bad
);

  logic        ok;
  int unsigned bits;
  logic [63:0] mask64;
  logic [63:0] f64;
  logic [63:0] x64;

  always_comb begin
    ok     = access_ok(int_mode, wid, idx[0], XLEN, FLEN);
    bits   = wid_bits(wid);
    mask64 = low_mask(bits);
    f64    = 64'(f_word) | ~low_mask(FLEN);
    x64    = 64'(x_lo);
    bad    = !ok;
    data   = '0;
    if (ok) begin
      if (!int_mode) begin
        // R4: padding must be all ones, else canonical NaN
        if (&(f64 | mask64)) data = FLEN'(f64 & mask64);
        else                 data = FLEN'(canon_nan(bits));
      end else if (XLEN == 32 && bits == 64) begin
        // R8: pair assembly, pair zero reads zero
        if (idx != '0) data = FLEN'({32'(x_hi), 32'(x_lo)});
      end else if (idx != '0) begin
        data = FLEN'(x64 & mask64); // R5, R7
      end
    end
  end

endmodule

// File: rtl/fxr_wr_ctrl.sv
module fxr_wr_ctrl
  import fxr_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int FLEN  = 64,
  parameter int IDX_W = 5
) (
  input  logic             wr_en,
  input  logic             int_mode,
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       wid,
  input  logic [FLEN-1:0]  data,
  output logic             f_we,
  output logic [FLEN-1:0]  f_val,
  output logic             xl_we,
  output logic [XLEN-1:0]  xl_val,
  output logic             xh_we,
  output logic [XLEN-1:0]  xh_val,
  output logic             bad
);

  logic        ok;
  logic        pair;
  int unsigned bits;
  logic [63:0] mask64;
  logic [63:0] d64;
  logic        sbit;

  always_comb begin
    ok     = access_ok(int_mode, wid, idx[0], XLEN, FLEN);
    bits   = wid_bits(wid);
    mask64 = low_mask(bits);
    d64    = 64'(data);
    sbit   = (bits != 0) ? d64[bits-1] : 1'b0;
    pair   = (XLEN == 32) && (bits == 64);
    bad    = wr_en && !ok;

    f_we   = wr_en && ok && !int_mode;
    f_val  = FLEN'((d64 & mask64) | ~mask64);          // R3

    xl_we  = wr_en && ok && int_mode && (idx != '0);    // R7, R9
    xh_we  = xl_we && pair;
    if (pair) begin
      xl_val = XLEN'(d64[31:0]);
      xh_val = XLEN'(d64[63:32]);
    end else begin
      xl_val = XLEN'((d64 & mask64) | (sbit ? ~mask64 : 64'd0)); // R6
      xh_val = '0;
    end
  end

endmodule

// File: rtl/shared_fp_regs.sv
module shared_fp_regs
  import fxr_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int FLEN  = 64,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_int_mode,
  input  logic [IDX_W-1:0] ra_idx,
  input  logic [1:0]       ra_wid,
  output logic [FLEN-1:0]  ra_data,
  input  logic [IDX_W-1:0] rb_idx,
  input  logic [1:0]       rb_wid,
  output logic [FLEN-1:0]  rb_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [1:0]       wr_wid,
  input  logic [FLEN-1:0]  wr_data,
  output logic             illegal
);

  localparam int NREG = 1 << IDX_W;

  logic [FLEN-1:0] f_q [NREG];
  logic [XLEN-1:0] x_q [NREG];

  logic            f_we, xl_we, xh_we, wr_bad, ra_bad, rb_bad;
  logic [FLEN-1:0] f_val;
  logic [XLEN-1:0] xl_val, xh_val;
  logic [IDX_W-1:0] wr_idx_p1;
  logic [63:0]     wr_data64;

  assign wr_idx_p1 = wr_idx + 1'b1;
  assign wr_data64 = 64'(wr_data);

  fxr_wr_ctrl #(.XLEN(XLEN), .FLEN(FLEN), .IDX_W(IDX_W)) u_wr (
    .wr_en(wr_en), .int_mode(cfg_int_mode), .idx(wr_idx), .wid(wr_wid),
    .data(wr_data), .f_we(f_we), .f_val(f_val), .xl_we(xl_we),
    .xl_val(xl_val), .xh_we(xh_we), .xh_val(xh_val), .bad(wr_bad)
  );

  fxr_rd_port #(.XLEN(XLEN), .FLEN(FLEN), .IDX_W(IDX_W)) u_rd_a (
    .int_mode(cfg_int_mode), .idx(ra_idx), .wid(ra_wid),
    .f_word(f_q[ra_idx]), .x_lo(x_q[ra_idx]), .x_hi(x_q[ra_idx + 1'b1]),
    .data(ra_data), .bad(ra_bad)
  );

  fxr_rd_port #(.XLEN(XLEN), .FLEN(FLEN), .IDX_W(IDX_W)) u_rd_b (
    .int_mode(cfg_int_mode), .idx(rb_idx), .wid(rb_wid),
    .f_word(f_q[rb_idx]), .x_lo(x_q[rb_idx]), .x_hi(x_q[rb_idx + 1'b1]),
    .data(rb_data), .bad(rb_bad)
  );

  assign illegal = ra_bad | rb_bad | wr_bad;

  // Float file
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NREG; k++) f_q[k] <= '0;   // R1
    end else if (f_we) begin
      f_q[wr_idx] <= f_val;
    end
  end

  // Integer file: low half (or single register) and high half of a pair
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NREG; k++) x_q[k] <= '0;   // R1
    end else begin
      if (xl_we) x_q[wr_idx]    <= xl_val;
      if (xh_we) x_q[wr_idx_p1] <= xh_val;
    end
  end

  a_r7_x0_zero: assert property (@(posedge clk) disable iff (rst)
    x_q[0] == '0);

  a_r3_nan_box: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !cfg_int_mode && wr_wid == 2'b00)
    |=> (&f_q[$past(wr_idx)][FLEN-1:16]));

  a_r11_int_keeps_float: assert property (@(posedge clk) disable iff (rst)
    (wr_en && cfg_int_mode) |=> (f_q[$past(wr_idx)] == $past(f_q[wr_idx])));

  a_r2_rsvd_flag: assert property (@(posedge clk) disable iff (rst)
    (ra_wid == 2'b11 || rb_wid == 2'b11) |-> illegal);

  generate
    if (XLEN == 32) begin : g_pair_chk
      a_r9_pair_high: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cfg_int_mode && wr_wid == 2'b10 && wr_idx != '0 && !wr_idx[0])
        |=> (x_q[$past(wr_idx_p1)] == $past(wr_data64[63:32])));

      a_r10_odd_pair_nowrite: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cfg_int_mode && wr_wid == 2'b10 && wr_idx[0])
        |=> (x_q[$past(wr_idx)] == $past(x_q[wr_idx])));
    end
  endgenerate

endmodule

// File: tb/shared_fp_regs_tb.sv
module shared_fp_regs_tb;

  localparam int XLEN = 32;
  localparam int FLEN = 64;

  logic            clk = 1'b0;
  logic            rst;
  logic            cfg_int_mode;
  logic [4:0]      ra_idx, rb_idx, wr_idx;
  logic [1:0]      ra_wid, rb_wid, wr_wid;
  logic [FLEN-1:0] ra_data, rb_data, wr_data;
  logic            wr_en, illegal;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk; // 50 MHz

  shared_fp_regs #(.XLEN(XLEN), .FLEN(FLEN), .IDX_W(5)) u_dut (
    .clk(clk), .rst(rst), .cfg_int_mode(cfg_int_mode),
    .ra_idx(ra_idx), .ra_wid(ra_wid), .ra_data(ra_data),
    .rb_idx(rb_idx), .rb_wid(rb_wid), .rb_data(rb_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_wid(wr_wid), .wr_data(wr_data),
    .illegal(illegal)
  );

  // Row: req[145:138] mode[137] wr[136] idx[135:131] wid[130:129]
  //      data[128:65] exp[64:1] ill[0]
  function automatic logic [145:0] mk(input int req, input logic m, input logic w,
                                      input logic [4:0] i, input logic [1:0] wd,
                                      input logic [63:0] d, input logic [63:0] e,
                                      input logic il);
    return {8'(req), m, w, i, wd, d, e, il};
  endfunction

  localparam int NV = 34;
  localparam logic [145:0] VEC [NV] = '{
    // integer mode
    mk(5,  1, 1, 3,  2'b01, 64'h1234_5678, 0, 0),
    mk(5,  1, 0, 3,  2'b01, 0, 64'h1234_5678, 0),
    mk(5,  1, 0, 3,  2'b00, 0, 64'h5678, 0),                     // R5 low bits
    mk(6,  1, 1, 5,  2'b00, 64'h8001, 0, 0),
    mk(6,  1, 0, 5,  2'b01, 0, 64'hFFFF_8001, 0),                // R6 sign extend
    mk(9,  1, 1, 4,  2'b10, 64'hAABB_CCDD_1122_3344, 0, 0),
    mk(8,  1, 0, 4,  2'b10, 0, 64'hAABB_CCDD_1122_3344, 0),      // R8 pair read
    mk(9,  1, 0, 5,  2'b01, 0, 64'hAABB_CCDD, 0),                // R9 high half
    mk(9,  1, 0, 4,  2'b01, 0, 64'h1122_3344, 0),                // R9 low half
    mk(9,  1, 1, 0,  2'b10, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0),
    mk(8,  1, 0, 0,  2'b10, 0, 0, 0),                            // R8 pair zero
    mk(9,  1, 0, 1,  2'b01, 0, 0, 0),                            // R9 suppressed
    mk(10, 1, 1, 7,  2'b10, 64'hDEAD_BEEF_CAFE_F00D, 0, 1),
    mk(10, 1, 0, 7,  2'b01, 0, 0, 0),                            // R10 no write
    mk(10, 1, 0, 8,  2'b01, 0, 0, 0),
    mk(10, 1, 0, 7,  2'b10, 0, 0, 1),                            // R10 odd read
    mk(7,  1, 1, 0,  2'b01, 64'h55, 0, 0),
    mk(7,  1, 0, 0,  2'b01, 0, 0, 0),                            // R7 x0 zero
    mk(2,  1, 1, 6,  2'b11, 64'h77, 0, 1),
    mk(2,  1, 0, 6,  2'b01, 0, 0, 0),                            // R2 no write
    // float mode
    mk(11, 0, 0, 3,  2'b10, 0, 0, 0),                            // R11 float untouched
    mk(3,  0, 1, 3,  2'b01, 64'h3F80_0000, 0, 0),
    mk(3,  0, 0, 3,  2'b10, 0, 64'hFFFF_FFFF_3F80_0000, 0),      // R3 boxed
    mk(4,  0, 0, 3,  2'b01, 0, 64'h3F80_0000, 0),                // R4 good box
    mk(4,  0, 0, 3,  2'b00, 0, 64'h7E00, 0),                     // R4 bad box
    mk(4,  0, 1, 9,  2'b10, 64'h0123_4567_89AB_CDEF, 0, 0),
    mk(4,  0, 0, 9,  2'b01, 0, 64'h7FC0_0000, 0),                // R4 canon 32
    mk(3,  0, 1, 10, 2'b00, 64'hBEEF, 0, 0),
    mk(3,  0, 0, 10, 2'b10, 0, 64'hFFFF_FFFF_FFFF_BEEF, 0),
    mk(4,  0, 0, 10, 2'b01, 0, 64'hFFFF_BEEF, 0),
    mk(7,  0, 1, 0,  2'b10, 64'h4000_0000_0000_0000, 0, 0),
    mk(7,  0, 0, 0,  2'b10, 0, 64'h4000_0000_0000_0000, 0),      // R7 f0 normal
    mk(2,  0, 0, 11, 2'b11, 0, 0, 1),                            // R2 reserved
    mk(11, 1, 0, 3,  2'b01, 0, 64'h1234_5678, 0)                 // R11 int kept
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle_ports();
    wr_en = 0; wr_idx = 0; wr_wid = 2'b01; wr_data = '0;
    ra_idx = 0; ra_wid = 2'b01; rb_idx = 0; rb_wid = 2'b00;
  endtask

  initial begin
    #3_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1; cfg_int_mode = 1; idle_ports();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1 reset state
    ra_idx = 9; ra_wid = 2'b01; rb_idx = 4; rb_wid = 2'b10; #2;
    check("R1 int A", ra_data, 0);
    check("R1 int B pair", rb_data, 0);
    check("R1 illegal", 64'(illegal), 0);
    cfg_int_mode = 0; ra_wid = 2'b10; rb_wid = 2'b01; #2;
    check("R1 float 64", ra_data, 0);
    check("R1 R4 float 32 of zero", rb_data, 64'h7FC0_0000);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [145:0] r;
      @(negedge clk);
      r = VEC[v];
      idle_ports();
      cfg_int_mode = r[137];
      if (r[136]) begin
        wr_en = 1; wr_idx = r[135:131]; wr_wid = r[130:129]; wr_data = r[128:65];
        ra_idx = 0; ra_wid = r[137] ? 2'b01 : 2'b10;
      end else begin
        ra_idx = r[135:131]; ra_wid = r[130:129];
      end
      #2;
      if (!r[136]) check($sformatf("R%0d row %0d data", r[145:138], v), ra_data, r[64:1]);
      check($sformatf("R%0d row %0d illegal", r[145:138], v), 64'(illegal), 64'(r[0]));
    end

    // R12: write and read of the same register in one cycle
    @(negedge clk);
    idle_ports(); cfg_int_mode = 1;
    wr_en = 1; wr_idx = 12; wr_wid = 2'b01; wr_data = 64'hCAFE_0001;
    rb_idx = 12; rb_wid = 2'b01; #2;
    check("R12 B before edge", rb_data, 0);
    @(negedge clk);
    wr_wid = 2'b10; wr_data = 64'h1111_2222_3333_4444;
    ra_idx = 13; ra_wid = 2'b01; #2;
    check("R12 B after edge", rb_data, 64'hCAFE_0001);
    check("R12 A pair high before edge", ra_data, 0);
    @(negedge clk);
    wr_en = 0; #2;
    check("R12 A pair high after edge", ra_data, 64'h1111_2222);
    check("R12 B pair low after edge", rb_data, 64'h3333_4444);

    // R1 reset clears written contents
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    ra_idx = 3; ra_wid = 2'b01; #2;
    check("R1 int after reset", ra_data, 0);
    cfg_int_mode = 0; ra_wid = 2'b10; #2;
    check("R1 float after reset", ra_data, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule